// File: doc/BRIEF.md
# Command Packet Framer and Serial Sender

This block turns a host request into a generic command packet and sends it on a single serial line. The host starts a packet by offering a type modifier, a specifier and a payload byte count on a valid/ready request port. The payload bytes then arrive on a byte-wide valid/ready stream. The block emits the packet as a run of 16-bit words. The packet starts with the fixed generic packet type and a running packet identifier. The host's three fields follow. The payload, packed two bytes per word, comes next, and a constant check word closes the packet.

Each word goes out as an asynchronous frame: a low start bit, the sixteen data bits least significant first, and two high stop bits. Every bit lasts `CLK_PER_BIT` clocks, which is 10 Mbit/s at 100 MHz. The frames of one packet follow each other with no idle gap. `busy` covers the whole packet. A one-cycle `done` pulse marks the moment the last stop bit has left the line.

The control path is a named state machine:
- `ST_IDLE`: waits for a request.
- `ST_TYPE`, `ST_PID`, `ST_MOD`, `ST_SPEC`, `ST_LEN`: hand the header words to the serializer.
- `ST_BYTE_LO` and `ST_BYTE_HI`: collect payload bytes.
- `ST_DATA`: hands over a packed data word.
- `ST_CHECK`: hands over the check word.
- `ST_DRAIN`: waits for the line to finish.

The transitions are as follows:
- `ST_IDLE` moves to `ST_TYPE` when a request is taken.
- Each header state moves to the next one when the serializer takes its word.
- `ST_LEN` moves to `ST_CHECK` for an empty payload and to `ST_BYTE_LO` otherwise.
- `ST_BYTE_LO` moves to `ST_DATA` when the byte just taken was the last one, and to `ST_BYTE_HI` otherwise.
- `ST_BYTE_HI` moves to `ST_DATA`.
- `ST_DATA` moves back to `ST_BYTE_LO` while bytes remain, and to `ST_CHECK` when none do.
- `ST_CHECK` moves to `ST_DRAIN`.
- `ST_DRAIN` returns to `ST_IDLE` when the serializer goes quiet.

Top module: `cpk_framer`

## Requirements
- R1: After reset, `tx_line` is 1, `busy` and `done` are 0, `req_ready` is 1 and `pay_ready` is 0.
- R2: A packet is sent as words in this order: packet type, packet identifier, type modifier, specifier, byte length, data words, check word. The packet type word is 0xCC02.
- R3: The packet identifier is 0 for the first packet after reset and rises by one for each later packet, modulo 2^16.
- R4: The modifier, specifier and length words equal the values presented with the accepted request. The length word counts bytes.
- R5: Payload bytes are packed two per word, the earlier byte in bits 7:0. For an odd byte count the final word carries 0x00 in bits 15:8.
- R6: With a byte length of 0, the check word follows the length word directly, so the packet is six words long.
- R7: The last word of every packet is 0xABAB.
- R8: Each word is framed on `tx_line` as follows:
  - one start bit at 0;
  - data bits 0 to 15 in that order;
  - two stop bits at 1.
  
  Each bit lasts `CLK_PER_BIT` clocks. When payload bytes arrive in time, the frame starts of one packet lie exactly 19 bit periods apart.
- R9: A request is taken only in a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while idle. The fields are captured at that moment, and later changes to them do not alter the packet.
- R10: Exactly as many payload bytes as the length field are taken. `pay_ready` is low at all other times, and gaps in `pay_valid` stall collection without corrupting data.
- R11: `busy` is high from the cycle after acceptance until `done`. The first start bit begins two cycles after the acceptance cycle. `done` is high for exactly one cycle, two cycles after the last cycle of the final stop bit, and `busy` is low in that cycle.
- R12: While `busy` is low, `tx_line` stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_mod | input | 16 | Type modifier field |
| req_spec | input | 16 | Specifier field |
| req_len | input | 16 | Payload length in bytes |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte offered |
| pay_ready | output | 1 | Block takes the payload byte |
| tx_line | output | 1 | Serial output, high when idle |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse at packet end |

## Verification
The bench notes the cycle in which each request is taken. It expects the first start bit two cycles later and every following frame start 19 bit periods after the previous one. It expects `done` two cycles after the last stop bit ends. A decoder reads the line at the middle of every bit period, sampling on falling clock edges so that it never races the rising edge that moves the line. Payload handshakes and `req_ready` are counted at falling edges as well, because the values seen there are the ones the next rising edge acts on.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned BYTE_W     = 8;
    localparam logic [WORD_W-1:0] PKT_TYPE   = 16'hCC02;
    localparam logic [WORD_W-1:0] CHECK_WORD = 16'hABAB;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TYPE,
        ST_PID,
        ST_MOD,
        ST_SPEC,
        ST_LEN,
        ST_BYTE_LO,
        ST_BYTE_HI,
        ST_DATA,
        ST_CHECK,
        ST_DRAIN
    } seq_state_t;

endpackage

// File: rtl/cpk_baud_tick.sv
module cpk_baud_tick #(
    parameter int unsigned CLK_PER_BIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/cpk_serializer.sv
module cpk_serializer
    import cpk_pkg::*;
#(
    parameter int unsigned CLK_PER_BIT = 10,
    parameter int unsigned STOP_BITS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              word_valid,
    output logic              word_ready,
    output logic              active,
    output logic              tx_line
);
    localparam int unsigned FRAME_BITS = 1 + WORD_W + STOP_BITS;
    localparam int unsigned BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg_q;
    logic [BW-1:0]         bit_q;
    logic                  active_q;
    logic                  tick;
    logic                  last_tick;
    logic                  load;

    cpk_baud_tick #(.CLK_PER_BIT(CLK_PER_BIT)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active_q),
        .restart (load),
        .tick    (tick)
    );

    assign last_tick  = tick && (bit_q == LAST_BIT);
    assign word_ready = !active_q || last_tick;
    assign load       = word_valid && word_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            bit_q    <= '0;
            shreg_q  <= '1;
        end else if (load) begin
            active_q <= 1'b1;
            bit_q    <= '0;
            shreg_q  <= {{STOP_BITS{1'b1}}, word, 1'b0};
        end else if (last_tick) begin
            active_q <= 1'b0;
            bit_q    <= '0;
            shreg_q  <= '1;
        end else if (tick) begin
            bit_q    <= bit_q + 1'b1;
            shreg_q  <= {1'b1, shreg_q[FRAME_BITS-1:1]};
        end
    end

    assign active  = active_q;
    assign tx_line = active_q ? shreg_q[0] : 1'b1;

endmodule

// File: rtl/cpk_sequencer.sv
module cpk_sequencer
    import cpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_mod,
    input  logic [WORD_W-1:0] req_spec,
    input  logic [WORD_W-1:0] req_len,
    input  logic [BYTE_W-1:0] pay_data,
    input  logic              pay_valid,
    output logic              pay_ready,
    output logic [WORD_W-1:0] word,
    output logic              word_valid,
    input  logic              word_ready,
    input  logic              ser_active,
    output logic              busy,
    output logic              done
);
    seq_state_t        state_q, state_d;
    logic [WORD_W-1:0] mod_q, spec_q, len_q, left_q, pid_q;
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              done_q;
    logic              take_req, take_byte, word_taken;

    assign take_req   = (state_q == ST_IDLE) && req_valid;
    assign take_byte  = pay_ready && pay_valid;
    assign word_taken = word_valid && word_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)  state_d = ST_TYPE;
            ST_TYPE:    if (word_ready) state_d = ST_PID;
            ST_PID:     if (word_ready) state_d = ST_MOD;
            ST_MOD:     if (word_ready) state_d = ST_SPEC;
            ST_SPEC:    if (word_ready) state_d = ST_LEN;
            ST_LEN:     if (word_ready) state_d = (len_q == '0) ? ST_CHECK : ST_BYTE_LO;
            ST_BYTE_LO: if (pay_valid)  state_d = (left_q == WORD_W'(1)) ? ST_DATA : ST_BYTE_HI;
            ST_BYTE_HI: if (pay_valid)  state_d = ST_DATA;
            ST_DATA:    if (word_ready) state_d = (left_q == '0) ? ST_CHECK : ST_BYTE_LO;
            ST_CHECK:   if (word_ready) state_d = ST_DRAIN;
            ST_DRAIN:   if (!ser_active) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        word       = '0;
        word_valid = 1'b0;
        req_ready  = 1'b0;
        pay_ready  = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                busy      = 1'b0;
            end
            ST_TYPE: begin
                word       = PKT_TYPE;
                word_valid = 1'b1;
            end
            ST_PID: begin
                word       = pid_q;
                word_valid = 1'b1;
            end
            ST_MOD: begin
                word       = mod_q;
                word_valid = 1'b1;
            end
            ST_SPEC: begin
                word       = spec_q;
                word_valid = 1'b1;
            end
            ST_LEN: begin
                word       = len_q;
                word_valid = 1'b1;
            end
            ST_BYTE_LO, ST_BYTE_HI: begin
                pay_ready = 1'b1;
            end
            ST_DATA: begin
                word       = {hi_q, lo_q};
                word_valid = 1'b1;
            end
            ST_CHECK: begin
                word       = CHECK_WORD;
                word_valid = 1'b1;
            end
            ST_DRAIN: begin
                busy = 1'b1;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
    end

    // packet fields, payload packing and identifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q  <= '0;
            spec_q <= '0;
            len_q  <= '0;
            left_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            pid_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_DRAIN) && !ser_active;
            if (take_req) begin
                mod_q  <= req_mod;
                spec_q <= req_spec;
                len_q  <= req_len;
                left_q <= req_len;
            end
            if (take_byte) begin
                left_q <= left_q - 1'b1;
                if (state_q == ST_BYTE_LO) begin
                    lo_q <= pay_data;
                    hi_q <= '0;
                end else begin
                    hi_q <= pay_data;
                end
            end
            if (word_taken && (state_q == ST_PID)) begin
                pid_q <= pid_q + 1'b1;
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/cpk_framer.sv
module cpk_framer
    import cpk_pkg::*;
#(
    parameter int unsigned CLK_PER_BIT = 10,
    parameter int unsigned STOP_BITS   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [15:0] req_mod,
    input  logic [15:0] req_spec,
    input  logic [15:0] req_len,
    input  logic [7:0]  pay_data,
    input  logic        pay_valid,
    output logic        pay_ready,
    output logic        tx_line,
    output logic        busy,
    output logic        done
);
    logic [WORD_W-1:0] word;
    logic              word_valid;
    logic              word_ready;
    logic              ser_active;

    cpk_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_mod    (req_mod),
        .req_spec   (req_spec),
        .req_len    (req_len),
        .pay_data   (pay_data),
        .pay_valid  (pay_valid),
        .pay_ready  (pay_ready),
        .word       (word),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .ser_active (ser_active),
        .busy       (busy),
        .done       (done)
    );

    cpk_serializer #(
        .CLK_PER_BIT (CLK_PER_BIT),
        .STOP_BITS   (STOP_BITS)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .word       (word),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .active     (ser_active),
        .tx_line    (tx_line)
    );

endmodule

// File: rtl/cpk_framer_checker.sv
module cpk_framer_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic pay_ready,
    input logic tx_line,
    input logic busy,
    input logic done
);
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && req_ready));

    assert_busy_ends_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_take_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    assert_pay_in_packet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> busy);

    assert_line_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

endmodule

bind cpk_framer cpk_framer_checker u_cpk_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .pay_ready (pay_ready),
    .tx_line   (tx_line),
    .busy      (busy),
    .done      (done)
);

// File: tb/cpk_framer_bench.sv
module cpk_framer_bench;
    localparam int CPB   = 10;
    localparam int FRAME = 19 * CPB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_mod = '0, req_spec = '0, req_len = '0;
    logic [7:0]  pay_data = '0;
    logic        pay_valid = 1'b0;
    logic        pay_ready;
    logic        tx_line, busy, done;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int frame_errs = 0;
    int pay_acc = 0;
    logic [15:0] exp_pid = '0;
    logic [7:0]  pay_mem [0:31];
    logic [15:0] got_w [$];
    int          got_t [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cpk_framer #(.CLK_PER_BIT(CPB)) u_cpk_framer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mod(req_mod), .req_spec(req_spec), .req_len(req_len),
        .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
        .tx_line(tx_line), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // line decoder: mid-bit sampling on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_line == 1'b0) begin
                logic [15:0] w;
                int t0;
                t0 = cyc;
                repeat (CPB / 2) @(negedge clk);
                if (tx_line !== 1'b0) frame_errs++;
                for (int i = 0; i < 16; i++) begin
                    repeat (CPB) @(negedge clk);
                    w[i] = tx_line;
                end
                for (int i = 0; i < 2; i++) begin
                    repeat (CPB) @(negedge clk);
                    if (tx_line !== 1'b1) frame_errs++;
                end
                got_w.push_back(w);
                got_t.push_back(t0);
            end
        end
    end

    always @(negedge clk) if (pay_valid && pay_ready) pay_acc++;

    task automatic feed(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            pay_valid = 1'b0;
            repeat (gap) @(negedge clk);
            pay_data  = pay_mem[k];
            pay_valid = 1'b1;
            while (!pay_ready) @(negedge clk);
            @(negedge clk);
        end
        pay_data  = 8'hEE;   // surplus byte that must not be taken (R10)
        pay_valid = 1'b1;
    endtask

    task automatic send_packet(input logic [15:0] m, input logic [15:0] s,
                               input int n, input int gap);
        int acc_cyc, done_cyc, rdy_busy, t, nw, last;
        logic [15:0] exp_w [$];
        got_w.delete();
        got_t.delete();
        pay_acc = 0;
        frame_errs = 0;
        rdy_busy = 0;
        @(negedge clk);
        req_valid = 1'b1; req_mod = m; req_spec = s; req_len = n[15:0];
        while (!req_ready) @(negedge clk);
        acc_cyc = cyc;
        @(negedge clk);
        // change fields after acceptance: must be ignored (R9)
        req_valid = 1'b0; req_mod = ~m; req_spec = ~s; req_len = 16'h00FF;
        chk(busy === 1'b1, "R11 busy after accept", busy, 1);
        fork feed(n, gap); join_none
        t = 0;
        forever begin
            @(negedge clk);
            t++;
            if (done || t > 30000) break;
            if (req_ready) rdy_busy++;
        end
        done_cyc = cyc;
        chk(done === 1'b1, "R11 done seen", done, 1);
        chk(busy === 1'b0, "R11 busy low with done", busy, 0);
        @(negedge clk);
        chk(done === 1'b0, "R11 done one cycle", done, 0);
        pay_valid = 1'b0;
        chk(rdy_busy == 0, "R9 req_ready while busy", rdy_busy, 0);
        chk(pay_acc == n, "R10 bytes taken", pay_acc, n);
        chk(frame_errs == 0, "R8 start/stop bits", frame_errs, 0);

        exp_w.push_back(16'hCC02);
        exp_w.push_back(exp_pid);
        exp_w.push_back(m);
        exp_w.push_back(s);
        exp_w.push_back(n[15:0]);
        for (int i = 0; i < n; i += 2)
            exp_w.push_back({(i + 1 < n) ? pay_mem[i+1] : 8'h00, pay_mem[i]});
        exp_w.push_back(16'hABAB);
        nw = exp_w.size();
        chk(got_w.size() == nw, "R2 word count", got_w.size(), nw);
        if (got_w.size() == nw) begin
            chk(got_w[0] == exp_w[0], "R2 type word", got_w[0], exp_w[0]);
            chk(got_w[1] == exp_w[1], "R3 packet id", got_w[1], exp_w[1]);
            for (int i = 2; i < 5; i++)
                chk(got_w[i] == exp_w[i], "R4 header field", got_w[i], exp_w[i]);
            for (int i = 5; i < nw - 1; i++)
                chk(got_w[i] == exp_w[i], "R5 data word", got_w[i], exp_w[i]);
            chk(got_w[nw-1] == 16'hABAB, "R7 check word", got_w[nw-1], 16'hABAB);
            chk(got_t[0] == acc_cyc + 2, "R11 first start bit", got_t[0], acc_cyc + 2);
            for (int i = 1; i < nw; i++)
                chk(got_t[i] - got_t[i-1] == FRAME, "R8 frame spacing",
                    got_t[i] - got_t[i-1], FRAME);
            last = got_t[nw-1];
            chk(done_cyc == last + FRAME + 1, "R11 done timing", done_cyc, last + FRAME + 1);
        end
        exp_pid++;
    endtask

    task automatic test_reset();
        chk(tx_line === 1'b1, "R1 tx_line", tx_line, 1);
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done === 1'b0, "R1 done", done, 0);
        chk(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
        chk(pay_ready === 1'b0, "R1 pay_ready", pay_ready, 0);
    endtask

    task automatic test_idle_line();
        int bad;
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (tx_line !== 1'b1 || busy !== 1'b0) bad++;
        end
        chk(bad == 0, "R12 idle line high", bad, 0);
    endtask

    task automatic test_empty();
        send_packet(16'h0012, 16'h0004, 0, 0);
        chk(got_w.size() == 6, "R6 empty packet length", got_w.size(), 6);
        if (got_w.size() == 6)
            chk(got_w[4] == 16'h0000 && got_w[5] == 16'hABAB, "R6 check after length",
                got_w[5], 16'hABAB);
    endtask

    task automatic test_single_byte();
        pay_mem[0] = 8'h5A;
        send_packet(16'h1111, 16'h2222, 1, 0);
        if (got_w.size() == 7)
            chk(got_w[5] == 16'h005A, "R5 pad byte zero", got_w[5], 16'h005A);
    endtask

    task automatic test_even();
        for (int i = 0; i < 4; i++) pay_mem[i] = 8'(8'hA1 + i * 8'h11);
        send_packet(16'hBEEF, 16'h8001, 4, 0);
    endtask

    task automatic test_odd_stall();
        for (int i = 0; i < 7; i++) pay_mem[i] = 8'(8'h30 + i * 7);
        send_packet(16'h7E81, 16'h0FF0, 7, 3);
    endtask

    task automatic test_pattern();
        for (int i = 0; i < 3; i++) pay_mem[i] = (i[0]) ? 8'hFF : 8'h01;
        send_packet(16'hFFFF, 16'h0000, 3, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle_line();
        test_empty();
        test_single_byte();
        test_even();
        test_idle_line();
        test_odd_stall();
        test_pattern();
        test_idle_line();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

endmodule